// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs a synchronous burst read from an array of 16-bit words. A host opens a burst by pulling chip select and address valid low together on a clock edge. The block then counts out a programmable initial latency while holding a wait pin asserted. After that it issues one array read per clock, with a word address that follows either a wrapped or a linear pattern, over a fixed length or without end. Each word is presented one cycle after its read strobe, under a data-valid flag.

The configuration fields come from outside the block and are captured when the burst opens, so later changes have no effect on a burst already running. Raising chip select ends the burst at once. In continuous bursts, a cycle counter raises a flag when chip select has stayed low longer than the allowed window.

Top module: `burst_rd_seq`

## Requirements
- R1: During and right after the synchronous reset, `arr_rd`, `dvalid` and `cs_overrun` are 0, and `wait_o` sits at its inactive level, which is the inverse of `cfg_wait_pol`.
- R2: A burst opens only from idle, on a rising edge with `cs_n`=0 and `adv_n`=0. `start_addr` and all configuration fields are captured on that edge. Later changes to them, and further `adv_n` low pulses before `cs_n` returns high, have no effect on the outputs.
- R3: Let k be the opening edge. The effective latency E is `cfg_lat` (0 to 7) when `cfg_fixed_lat`=0 and twice `cfg_lat` when it is 1. Word i has `arr_rd`=1 in the cycle after edge k+E+i, and `dvalid`=1 in the cycle after edge k+E+i+1.
- R4: `cfg_len` selects 4 words with 001, 8 with 010, 16 with 011 and 32 with 100. Code 111, and every other code, selects a continuous burst.
- R5: With a fixed length N and `cfg_linear`=0, word i is read at address (start with its low log2(N) bits cleared) OR ((start+i) mod N).
- R6: In continuous mode (whatever `cfg_linear` is), and with `cfg_linear`=1, word i is read at start+i modulo 2^AW. With a fixed length and `cfg_linear`=1, exactly N reads are issued. `arr_rd` then falls, and `dvalid` falls one cycle later.
- R7: When `cfg_wait_early`=0, wait is active from the cycle after the opening edge up to, but not including, the first cycle with `dvalid`=1. When `cfg_wait_early`=1, wait is released one cycle sooner, so it is active for E cycles.
- R8: `cfg_wait_pol`=1 drives `wait_o` high when wait is active. `cfg_wait_pol`=0 drives it low. Outside the wait window, `wait_o` holds the opposite level.
- R9: A rising edge that samples `cs_n`=1 returns the block to idle. In the next cycle `arr_rd` and `dvalid` are 0, including for a word in flight, and wait is inactive.
- R10: In a continuous burst, `cs_overrun` becomes 1 after edge k+t once t ≥ CS_LIMIT, that is, once more than CS_LIMIT consecutive edges have sampled `cs_n` low. It stays 1 until `cs_n` goes high, and it is never set for fixed-length bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| start_addr | input | AW | Burst start word address |
| cfg_lat | input | 3 | Latency count, 0 to 7 |
| cfg_fixed_lat | input | 1 | 1 doubles the latency (fixed mode) |
| cfg_len | input | 3 | Burst length code |
| cfg_linear | input | 1 | 0 wraps inside the length block, 1 counts linearly |
| cfg_wait_early | input | 1 | 1 releases wait one cycle before data |
| cfg_wait_pol | input | 1 | 1 means wait is active high |
| arr_addr | output | AW | Array word address |
| arr_rd | output | 1 | Array read strobe |
| wait_o | output | 1 | Wait pin |
| dvalid | output | 1 | Data-valid flag |
| cs_overrun | output | 1 | Chip-select low time exceeded |

## Verification
The bench compares every cycle against a reference model that works out each output from the number of edges since the burst opened. It covers latency 0, which a design would get wrong by stalling a cycle or by asserting wait in early mode, and doubled latency 14, where a narrow counter would wrap. A start address near the top of a 32-word block, and one near the top of the address space, expose a wrap pattern that leaks into the upper bits. It also aborts bursts during latency and in mid-data, where a design that keeps the in-flight word would raise `dvalid` after `cs_n` has gone high. It pulses `adv_n` low during a burst, which a design that restarts on it would show as a reloaded address. It holds a continuous burst past the limit, and a design that counts off by one would raise the overrun flag a cycle early or late.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } bseq_state_e;

  typedef struct packed {
    logic [2:0] lat;
    logic       fixed_lat;
    logic [2:0] len;
    logic       linear;
    logic       early;
    logic       pol;
  } bseq_cfg_t;

  localparam int LAT_W = 4;
  localparam int CNT_W = 6;

  // words per burst for a length code; 0 means continuous
  function automatic logic [CNT_W-1:0] len_words(input logic [2:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      3'b001:  n = 6'd4;
      3'b010:  n = 6'd8;
      3'b011:  n = 6'd16;
      3'b100:  n = 6'd32;
      default: n = 6'd0;
    endcase
    return n;
  endfunction

  function automatic logic [LAT_W-1:0] eff_latency(input logic [2:0] lat,
                                                   input logic       fixed);
    return fixed ? {lat, 1'b0} : {1'b0, lat};
  endfunction

endpackage

// File: rtl/bseq_lat_timer.sv
module bseq_lat_timer #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  logic [LW-1:0] cnt_q;

  assign expire = run && (cnt_q == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int AW = 22,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] nwords,
  input  logic          wrap_mode,
  input  logic          issue,
  output logic [AW-1:0] issue_addr,
  output logic [CW-1:0] words_issued
);
  logic [AW-1:0] cur_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] mask;
  logic [AW-1:0] inc_addr;
  logic [AW-1:0] nxt_addr;
  logic [CW-1:0] cnt_base;

  assign issue_addr = start ? start_addr : cur_q;
  assign cnt_base   = start ? '0 : cnt_q;
  assign mask       = AW'(nwords) - 1'b1;
  assign inc_addr   = issue_addr + 1'b1;
  assign nxt_addr   = wrap_mode ? ((issue_addr & ~mask) | (inc_addr & mask)) : inc_addr;
  assign words_issued = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (issue) begin
      cur_q <= nxt_addr;
      cnt_q <= cnt_base + 1'b1;
    end else if (start) begin
      cur_q <= start_addr;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/bseq_cs_guard.sv
module bseq_cs_guard #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic start_cont,
  input  logic cs_n,
  output logic overrun
);
  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          track_q;

  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      track_q <= 1'b0;
      overrun <= 1'b0;
    end else if (cs_n) begin
      cnt_q   <= '0;
      track_q <= 1'b0;
      overrun <= 1'b0;
    end else if (start_cont) begin
      cnt_q   <= CW'(1);
      track_q <= 1'b1;
      overrun <= (LIMIT == 0);
    end else if (track_q && !overrun) begin
      cnt_q   <= cnt_inc;
      overrun <= (cnt_inc > CW'(LIMIT));
    end
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_seq_pkg::*;
#(
  parameter int AW       = 22,
  parameter int CS_LIMIT = 500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  input  logic [2:0]    cfg_lat,
  input  logic          cfg_fixed_lat,
  input  logic [2:0]    cfg_len,
  input  logic          cfg_linear,
  input  logic          cfg_wait_early,
  input  logic          cfg_wait_pol,
  output logic [AW-1:0] arr_addr,
  output logic          arr_rd,
  output logic          wait_o,
  output logic          dvalid,
  output logic          cs_overrun
);
  bseq_state_e st_q, st_n;
  bseq_cfg_t   cfg_in, cfg_q, cfg_e;

  logic             start;
  logic [LAT_W-1:0] lat_e;
  logic [CNT_W-1:0] nwords_e;
  logic             cont_e, linfix_e, wrapfix_e;
  logic             expire, first_issue, last_done, issue;
  logic [AW-1:0]    issue_addr;
  logic [CNT_W-1:0] words_issued;
  logic             issued_q, presented_q, issued_n, presented_n;
  logic             dvalid_n, busy_n, wait_act_n, wait_act_q, pol_n;
  logic             addr_linear;

  assign cfg_in = '{lat: cfg_lat, fixed_lat: cfg_fixed_lat, len: cfg_len,
                    linear: cfg_linear, early: cfg_wait_early, pol: cfg_wait_pol};

  assign start     = (st_q == ST_IDLE) && !cs_n && !adv_n;
  assign cfg_e     = start ? cfg_in : cfg_q;
  assign lat_e     = eff_latency(cfg_e.lat, cfg_e.fixed_lat);
  assign nwords_e  = len_words(cfg_e.len);
  assign cont_e    = (nwords_e == '0);
  assign linfix_e  = !cont_e && cfg_e.linear;
  assign wrapfix_e = !cont_e && !cfg_e.linear;
  assign addr_linear = !wrapfix_e;

  bseq_lat_timer #(.LW(LAT_W)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (lat_e),
    .run      (st_q == ST_LAT),
    .expire   (expire)
  );

  assign first_issue = (start && lat_e == '0) || expire;
  assign last_done   = linfix_e && (words_issued == nwords_e);
  assign issue       = !cs_n && (first_issue || (st_q == ST_XFER && !last_done));

  bseq_addr_gen #(.AW(AW), .CW(CNT_W)) u_addr (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_addr   (start_addr),
    .nwords       (nwords_e),
    .wrap_mode    (wrapfix_e),
    .issue        (issue),
    .issue_addr   (issue_addr),
    .words_issued (words_issued)
  );

  bseq_cs_guard #(.LIMIT(CS_LIMIT)) u_guard (
    .clk        (clk),
    .rst        (rst),
    .start_cont (start && cont_e),
    .cs_n       (cs_n),
    .overrun    (cs_overrun)
  );

  // next state
  always_comb begin
    st_n = st_q;
    if (cs_n) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (start) st_n = (lat_e == '0) ? ST_XFER : ST_LAT;
        ST_LAT:  if (expire) st_n = ST_XFER;
        ST_XFER: if (last_done) st_n = ST_DONE;
        default: st_n = st_q;
      endcase
    end
  end

  // wait window tracking
  always_comb begin
    dvalid_n    = !cs_n && arr_rd;
    issued_n    = !cs_n && (start ? first_issue : (issued_q || issue));
    presented_n = !cs_n && !start && (presented_q || dvalid_n);
    busy_n      = (st_n == ST_LAT) || (st_n == ST_XFER);
    wait_act_n  = busy_n && !(cfg_e.early ? issued_n : presented_n);
    pol_n       = (st_n == ST_IDLE) ? cfg_wait_pol : cfg_e.pol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cfg_q       <= '0;
      arr_rd      <= 1'b0;
      arr_addr    <= '0;
      dvalid      <= 1'b0;
      issued_q    <= 1'b0;
      presented_q <= 1'b0;
      wait_act_q  <= 1'b0;
      wait_o      <= ~cfg_wait_pol;
    end else begin
      st_q        <= st_n;
      if (start) cfg_q <= cfg_in;
      arr_rd      <= issue;
      if (issue) arr_addr <= issue_addr;
      dvalid      <= dvalid_n;
      issued_q    <= issued_n;
      presented_q <= presented_n;
      wait_act_q  <= wait_act_n;
      wait_o      <= wait_act_n ? pol_n : ~pol_n;
    end
  end
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          arr_rd,
  input logic [AW-1:0] arr_addr,
  input logic          dvalid,
  input logic          wait_act,
  input logic          linear_mode,
  input logic          cs_overrun
);
  // R9: chip select high ends everything on the next cycle
  a_r9_cs_ends_burst: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!arr_rd && !dvalid && !wait_act));

  // R3: a word is only presented after its read strobe
  a_r3_dvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(dvalid) |-> $past(arr_rd));

  // R7: wait is never active while data is presented
  a_r7_no_wait_with_data: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> !wait_act);

  // R6: linear addressing steps by one word
  a_r6_linear_step: assert property (@(posedge clk) disable iff (rst)
    (arr_rd && $past(arr_rd) && linear_mode && $past(linear_mode))
      |-> (arr_addr == $past(arr_addr) + 1'b1));

  // R10: the overrun flag rises only while chip select is held low
  a_r10_overrun_cs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_overrun) |-> !$past(cs_n));
endmodule

bind burst_rd_seq bseq_checker #(.AW(AW)) u_bseq_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .arr_rd      (arr_rd),
  .arr_addr    (arr_addr),
  .dvalid      (dvalid),
  .wait_act    (wait_act_q),
  .linear_mode (addr_linear),
  .cs_overrun  (cs_overrun)
);

// File: tb/burst_rd_seq_bench.sv
module burst_rd_seq_bench;
  localparam int AW  = 22;
  localparam int LIM = 500;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    cfg_lat = 3'd3;
  logic          cfg_fixed_lat = 1'b0;
  logic [2:0]    cfg_len = 3'b111;
  logic          cfg_linear = 1'b1;
  logic          cfg_wait_early = 1'b1;
  logic          cfg_wait_pol = 1'b1;
  logic [AW-1:0] arr_addr;
  logic          arr_rd, wait_o, dvalid, cs_overrun;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    fin = 1'b0;
  string scen = "R1";

  // reference model state
  bit            m_act = 1'b0;
  int            t = 0;
  int            m_e = 0;
  int            m_n = 0;
  bit            m_lin = 1'b0;
  int            m_early = 0;
  logic          m_pol = 1'b1;
  logic [AW-1:0] m_sa = '0;
  logic          e_rd = 1'b0;
  logic          e_dv = 1'b0;
  logic          e_ovr = 1'b0;
  logic          e_wait = 1'b0;
  logic [AW-1:0] e_addr = '0;

  always #2.5 clk = ~clk;

  burst_rd_seq #(.AW(AW), .CS_LIMIT(LIM)) u_burst_rd_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .start_addr(start_addr),
    .cfg_lat(cfg_lat), .cfg_fixed_lat(cfg_fixed_lat), .cfg_len(cfg_len),
    .cfg_linear(cfg_linear), .cfg_wait_early(cfg_wait_early),
    .cfg_wait_pol(cfg_wait_pol), .arr_addr(arr_addr), .arr_rd(arr_rd),
    .wait_o(wait_o), .dvalid(dvalid), .cs_overrun(cs_overrun)
  );

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b001: return 4;
      3'b010: return 8;
      3'b011: return 16;
      3'b100: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [AW-1:0] addr_of(input int i);
    logic [AW-1:0] ofs = AW'(i);
    logic [AW-1:0] msk;
    if (m_n != 0 && !m_lin) begin
      msk = AW'(m_n - 1);
      return (m_sa & ~msk) | ((m_sa + ofs) & msk);
    end
    return m_sa + ofs;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_act = 1'b0;
    end else if (cs_n) begin
      m_act = 1'b0;
    end else if (!m_act) begin
      if (!adv_n) begin
        m_act   = 1'b1;
        t       = 0;
        m_sa    = start_addr;
        m_e     = cfg_fixed_lat ? 2 * int'(cfg_lat) : int'(cfg_lat);
        m_n     = len_of(cfg_len);
        m_lin   = cfg_linear;
        m_early = cfg_wait_early ? 1 : 0;
        m_pol   = cfg_wait_pol;
      end
    end else begin
      t++;
    end
    if (!m_act) begin
      e_rd = 1'b0; e_dv = 1'b0; e_ovr = 1'b0; e_wait = ~cfg_wait_pol;
    end else begin
      int i;
      i      = t - m_e;
      e_rd   = (i >= 0) && (m_n == 0 || !m_lin || i < m_n);
      e_addr = addr_of(i);
      e_dv   = (i >= 1) && (m_n == 0 || !m_lin || i - 1 < m_n);
      e_wait = (t <= m_e - m_early) ? m_pol : ~m_pol;
      e_ovr  = (m_n == 0) && (t >= LIM);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s scen %s at cycle %0d act %h exp %h",
               req, what, scen, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!fin) begin
      chk("R3", "arr_rd", 32'(arr_rd), 32'(e_rd));
      if (e_rd) chk((m_n != 0 && !m_lin) ? "R5" : "R6", "arr_addr",
                    32'(arr_addr), 32'(e_addr));
      chk("R3", "dvalid", 32'(dvalid), 32'(e_dv));
      chk("R7", "wait_o", 32'(wait_o), 32'(e_wait));
      chk("R10", "cs_overrun", 32'(cs_overrun), 32'(e_ovr));
    end
  end

  task automatic finish_run();
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog scen %s act %0d exp below 20000", scen, cycles);
      finish_run();
    end
  end

  task automatic burst(input string tag, input logic [AW-1:0] sa,
                       input int lat, input int fx, input int len, input int lin,
                       input int early, input int pol, input int hold, input int adv_at);
    scen           = tag;
    start_addr     = sa;
    cfg_lat        = 3'(lat);
    cfg_fixed_lat  = fx[0];
    cfg_len        = 3'(len);
    cfg_linear     = lin[0];
    cfg_wait_early = early[0];
    cfg_wait_pol   = pol[0];
    cs_n           = 1'b0;
    adv_n          = 1'b0;
    @(negedge clk);
    adv_n          = 1'b1;
    start_addr     = ~sa;
    cfg_lat        = ~cfg_lat;
    cfg_len        = ~cfg_len;
    cfg_linear     = ~cfg_linear;
    cfg_wait_early = ~cfg_wait_early;
    cfg_fixed_lat  = ~cfg_fixed_lat;
    for (int k = 1; k <= hold; k++) begin
      adv_n = (k == adv_at) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    cs_n  = 1'b1;
    adv_n = 1'b1;
    cfg_wait_pol = pol[0];
    repeat (2) @(negedge clk);
  endtask

  initial begin
    scen = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // latency 3, 4-word wrap, start near top of block
    burst("R5", 22'h000106, 3, 0, 3'b001, 0, 0, 1, 14, 0);
    // zero latency, early wait, 8-word wrap
    burst("R7", 22'h00023D, 0, 0, 3'b010, 0, 1, 1, 16, 0);
    // zero latency, aligned wait, active-low polarity
    burst("R8", 22'h000040, 0, 0, 3'b010, 1, 0, 0, 10, 0);
    // doubled latency 14, 16-word linear stop, adv pulse ignored
    burst("R6", 22'h000FFA, 7, 1, 3'b011, 1, 0, 1, 40, 5);
    // 32-word wrap near block top, active-low, restart attempt
    burst("R2", 22'h12345E, 2, 0, 3'b100, 0, 1, 0, 40, 9);
    // all length codes, including reserved ones
    for (int c = 0; c < 8; c++)
      burst("R4", 22'h00A0F3, 1, 0, c, (c % 2), 0, 1, 38, 0);
    // abort during latency, then mid-data
    burst("R9", 22'h000777, 5, 0, 3'b011, 1, 0, 1, 3, 0);
    burst("R9", 22'h000777, 1, 0, 3'b011, 1, 1, 0, 5, 0);
    // continuous at the top of the address space, short then past the limit
    burst("R6", 22'h3FFFFC, 4, 0, 3'b111, 0, 0, 1, 30, 0);
    burst("R10", 22'h3FFFF0, 3, 1, 3'b111, 1, 1, 1, LIM + 20, 0);
    burst("R10", 22'h000100, 0, 0, 3'b011, 0, 0, 1, LIM + 5, 0);
    // reset in the middle of a burst
    scen = "R1";
    cs_n = 1'b0; adv_n = 1'b0; cfg_len = 3'b111; cfg_wait_pol = 1'b0;
    @(negedge clk);
    adv_n = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule